// File: doc/BRIEF.md
# Ring-Oscillator Frequency Meter

This block measures how fast an on-chip oscillator runs by timing it against the block's own reference clock. Software programs a window length expressed in cycles of the measured clock, opens a gate that lets the measured clock drive the window counter, and then arms the meter. The meter counts reference-clock cycles for exactly the span of that many measured cycles and reports the total. A slower oscillator therefore gives a larger count; the oscillator frequency is the window length divided by the count, times the reference frequency.

The measured clock runs in its own domain. The start and the end of the window are each marked by one toggle of a single signal, which crosses into the reference domain through a two-flop synchronizer. Both marks go through the same synchronizer, so its delay cancels and the count is accurate to within one reference cycle. A result of zero means no window completed and is the failure outcome. A valid flag tells software when the result is ready. The flag stays set until the meter is disarmed.

Top module: `ringosc_freq_meter`

## Requirements
- R1: After reset, the control word, the result word and the status word all read as zero.
- R2: The register map uses word address 0 for control, 1 for result and 2 for status. Control holds the window length in bits 23:0 and the arm bit in bit 24. Result holds the count in its low RES_W bits. Status holds the gate enable in bit 8, which can be written and read back, and the valid flag in bit 0, which is read-only. Unused bits and address 3 read as zero, and writing 1 to the valid bit has no effect.
- R3: With the gate and the arm bit set and a window of W measured cycles, the result is within one of W times the measured period divided by the reference period.
- R4: Once valid is set, valid and the result stay unchanged for as long as the arm bit stays set.
- R5: Clearing the arm bit clears valid and sets the result to zero by the next cycle.
- R6: While the gate is off, no window completes, even if the meter is armed. Valid stays 0 and the result reads 0, which is the failure outcome.
- R7: The reference count saturates at all-ones and never wraps. A window longer than the result width can hold reads as all-ones.
- R8: Window values 0 and 1 both span exactly one measured-clock cycle.
- R9: With the gate on but the arm bit clear, no measurement takes place: valid stays 0 and the result stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; registers and reference counter |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| meas_clk | input | 1 | Oscillator clock being measured |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
On every cycle, the assertions check the following: valid and the result stay fixed while the meter remains armed, disarming clears both, the reference counter holds at all-ones instead of wrapping, and the measured-domain toggle stays quiet while the meter is not armed. Only the bench's scenarios can show that the count matches the frequency ratio. They do this at several period ratios and window lengths that include the trivial windows 0 and 1. The scenarios also show that the gated-off and disarmed cases yield the zero failure result, and that the register layout reads back as specified.

// File: rtl/fmeter_pkg.sv
package fmeter_pkg;

    localparam int REG_DATA_W     = 32;
    localparam int REG_ADDR_W     = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_RESULT = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd2;

    localparam int CTRL_ARM_BIT   = 24;
    localparam int WIN_W          = CTRL_ARM_BIT;
    localparam int STAT_GATE_BIT  = 8;
    localparam int STAT_VALID_BIT = 0;

    typedef struct packed {
        logic             arm;
        logic             gate;
        logic [WIN_W-1:0] window;
    } fm_ctrl_t;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } ref_phase_e;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_COUNT = 2'd1,
        MS_HOLD  = 2'd2
    } meas_state_e;

    // True once the measured-cycle counter, holding completed cycles minus one,
    // has covered the window. Windows 0 and 1 both end after one cycle.
    function automatic logic window_reached(input logic [WIN_W-1:0] cnt,
                                            input logic [WIN_W-1:0] win);
        logic [WIN_W:0] next;
        next = {1'b0, cnt} + 1'b1;
        return next >= {1'b0, win};
    endfunction

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int   STAGES  = 2,
    parameter bit   USE_RST = 1'b1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (USE_RST) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) pipe <= {STAGES{RST_VAL}};
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end else begin : g_norst
            always_ff @(posedge clk) begin
                pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/fm_meas_side.sv
module fm_meas_side
    import fmeter_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             meas_clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [WIN_W-1:0] window,
    output logic             mark_tog
);
    logic        rst_m;
    logic        arm_s;
    meas_state_e st;
    logic [WIN_W-1:0] cnt;

    fm_sync #(.STAGES(SYNC_STAGES), .USE_RST(1'b0), .RST_VAL(1'b1)) u_rst_sync (
        .clk (meas_clk), .rst (1'b0), .d (rst), .q (rst_m)
    );

    fm_sync #(.STAGES(SYNC_STAGES), .USE_RST(1'b1), .RST_VAL(1'b0)) u_arm_sync (
        .clk (meas_clk), .rst (rst_m), .d (arm), .q (arm_s)
    );

    always_ff @(posedge meas_clk) begin
        if (rst_m) begin
            st       <= MS_IDLE;
            cnt      <= '0;
            mark_tog <= 1'b0;
        end else if (!arm_s) begin
            st  <= MS_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                MS_IDLE: begin
                    mark_tog <= ~mark_tog;
                    cnt      <= '0;
                    st       <= MS_COUNT;
                end
                MS_COUNT: begin
                    if (window_reached(cnt, window)) begin
                        mark_tog <= ~mark_tog;
                        st       <= MS_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: without an armed, gated clock no window mark is emitted
    a_r6_quiet_when_idle: assert property (@(posedge meas_clk) disable iff (rst_m)
        !arm_s |=> $stable(mark_tog));

    // R8: short windows close after the first counted cycle
    a_r8_short_window: assert property (@(posedge meas_clk) disable iff (rst_m)
        (st == MS_COUNT && arm_s && window <= 1) |=> (st != MS_COUNT));
endmodule

// File: rtl/fm_ref_side.sv
module fm_ref_side
    import fmeter_pkg::*;
#(
    parameter int RES_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_en,
    input  logic             gate_en,
    input  logic             mark_tog,
    output logic             arm_out,
    output logic             valid,
    output logic [RES_W-1:0] result
);
    localparam logic [RES_W-1:0] CNT_MAX = {RES_W{1'b1}};

    logic             tog_s, tog_d, mark;
    ref_phase_e       phase;
    logic [RES_W-1:0] cnt;

    function automatic logic [RES_W-1:0] sat_inc(input logic [RES_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) arm_out <= 1'b0;
        else     arm_out <= arm_en & gate_en;
    end

    fm_sync #(.STAGES(SYNC_STAGES), .USE_RST(1'b1), .RST_VAL(1'b0)) u_tog_sync (
        .clk (clk), .rst (rst), .d (mark_tog), .q (tog_s)
    );

    always_ff @(posedge clk) begin
        if (rst) tog_d <= 1'b0;
        else     tog_d <= tog_s;
    end

    assign mark = tog_s ^ tog_d;

    always_ff @(posedge clk) begin
        if (rst || !arm_en) begin
            phase  <= PH_WAIT;
            cnt    <= '0;
            valid  <= 1'b0;
            result <= '0;
        end else begin
            case (phase)
                PH_WAIT: begin
                    if (mark) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end
                end
                PH_RUN: begin
                    if (mark) begin
                        phase  <= PH_DONE;
                        valid  <= 1'b1;
                        result <= sat_inc(cnt);
                    end else begin
                        cnt <= sat_inc(cnt);
                    end
                end
                default: ;
            endcase
        end
    end

    a_r4_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        (valid && arm_en) |=> valid);

    a_r4_result_frozen: assert property (@(posedge clk) disable iff (rst)
        (valid && arm_en) |=> $stable(result));

    a_r5_disarm_clears: assert property (@(posedge clk) disable iff (rst)
        !arm_en |=> (!valid && result == '0));

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && arm_en && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    a_r3_valid_from_run: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> ($past(phase) == PH_RUN));
endmodule

// File: rtl/fm_regs.sv
module fm_regs
    import fmeter_pkg::*;
#(
    parameter int RES_W = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_DATA_W-1:0] wdata,
    input  logic                  valid,
    input  logic [RES_W-1:0]      result,
    output fm_ctrl_t              ctrl,
    output logic [REG_DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            if (addr == ADDR_CTRL) begin
                ctrl.window <= wdata[WIN_W-1:0];
                ctrl.arm    <= wdata[CTRL_ARM_BIT];
            end
            if (addr == ADDR_STATUS) begin
                ctrl.gate <= wdata[STAT_GATE_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[WIN_W-1:0]   = ctrl.window;
                rdata[CTRL_ARM_BIT] = ctrl.arm;
            end
            ADDR_RESULT: rdata[RES_W-1:0] = result;
            ADDR_STATUS: begin
                rdata[STAT_GATE_BIT]  = ctrl.gate;
                rdata[STAT_VALID_BIT] = valid;
            end
            default: rdata = '0;
        endcase
    end

    // R2: the valid bit is read-only; a status write never sets it by itself
    a_r2_valid_readonly: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_STATUS && !valid && !ctrl.arm) |=> !valid);
endmodule

// File: rtl/ringosc_freq_meter.sv
module ringosc_freq_meter
    import fmeter_pkg::*;
#(
    parameter int RES_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        meas_clk,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    fm_ctrl_t         ctrl;
    logic             valid;
    logic [RES_W-1:0] result;
    logic             arm_x;
    logic             mark_tog;

    fm_regs #(.RES_W(RES_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .valid  (valid),
        .result (result),
        .ctrl   (ctrl),
        .rdata  (reg_rdata)
    );

    fm_ref_side #(.RES_W(RES_W), .SYNC_STAGES(SYNC_STAGES)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .arm_en   (ctrl.arm),
        .gate_en  (ctrl.gate),
        .mark_tog (mark_tog),
        .arm_out  (arm_x),
        .valid    (valid),
        .result   (result)
    );

    fm_meas_side #(.SYNC_STAGES(SYNC_STAGES)) u_meas (
        .meas_clk (meas_clk),
        .rst      (rst),
        .arm      (arm_x),
        .window   (ctrl.window),
        .mark_tog (mark_tog)
    );
endmodule

// File: tb/tb_ringosc_freq_meter.sv
`timescale 1ns/1ps
module tb_ringosc_freq_meter;
    localparam int RES_W   = 12;
    localparam int REF_PS  = 10000;
    localparam int RES_MAX = (1 << RES_W) - 1;

    typedef struct {
        string  tag;
        longint ideal_ps;
        longint tol_ps;
    } exp_t;

    logic        clk = 1'b0;
    logic        meas_clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    realtime     meas_half = 5.15;

    int     n_chk = 0;
    int     n_bad = 0;
    bit     finished = 1'b0;
    exp_t   exp_q[$];
    longint act_q[$];

    ringosc_freq_meter #(.RES_W(RES_W)) dut (
        .clk       (clk),
        .rst       (rst),
        .meas_clk  (meas_clk),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #5 clk = ~clk;
    initial forever #(meas_half) meas_clk = ~meas_clk;

    task automatic check(input string tag, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Monitor: pairs each expected item with the result the driver observed
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0 && exp_q.size() > 0) begin
                exp_t   e;
                longint a;
                longint diff;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                diff = a * REF_PS - e.ideal_ps;
                if (diff < 0) diff = -diff;
                n_chk++;
                if (diff > e.tol_ps) begin
                    n_bad++;
                    $display("FAIL %s: actual=%0d expected=%0d ref cycles (tol %0d ps)",
                             e.tag, a, e.ideal_ps / REF_PS, e.tol_ps);
                end
            end
        end
    end

    // Driver: one full measurement sequence, expected value pushed to the scoreboard
    task automatic measure(input string tag, input realtime period_ns,
                           input int win, input longint ideal_ps, input longint tol_ps);
        logic [31:0] st;
        logic [31:0] res;
        logic [31:0] res2;
        bit          got;
        meas_half = period_ns / 2.0;
        repeat (5) @(negedge clk);
        reg_write(2'd2, 32'h0000_0100);
        reg_write(2'd0, (32'h1 << 24) | (win & 32'h00FF_FFFF));
        got = 1'b0;
        for (int i = 0; i < 20000 && !got; i++) begin
            reg_read(2'd2, st);
            got = st[0];
        end
        check({tag, " valid seen"}, got, 1);
        exp_q.push_back('{tag, ideal_ps, tol_ps});
        reg_read(2'd1, res);
        act_q.push_back(longint'(res));
        repeat (30) @(negedge clk);
        reg_read(2'd2, st);
        check("R4 valid held while armed", st[0], 1);
        reg_read(2'd1, res2);
        check("R4 result held while armed", res2, res);
        reg_write(2'd0, win & 32'h00FF_FFFF);
        reg_read(2'd2, st);
        check("R5 valid cleared on disarm", st[0], 0);
        reg_read(2'd1, res2);
        check("R5 result zero on disarm", res2, 0);
        reg_write(2'd2, 32'h0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        reg_read(2'd0, d); check("R1 control after reset", d, 0);
        reg_read(2'd1, d); check("R1 result after reset", d, 0);
        reg_read(2'd2, d); check("R1 status after reset", d, 0);

        reg_write(2'd0, 32'h00AB_CDEF);
        reg_read(2'd0, d); check("R2 window field readback", d, 32'h00AB_CDEF);
        reg_write(2'd0, 32'hFF00_0000);
        reg_read(2'd0, d); check("R2 arm bit alone, upper bits dropped", d, 32'h0100_0000);
        reg_write(2'd0, 32'h0);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_read(2'd2, d); check("R2 status: gate only, valid write ignored", d, 32'h0000_0100);
        reg_read(2'd3, d); check("R2 address 3 reads zero", d, 0);
        reg_read(2'd1, d); check("R2 result untouched by status write", d, 0);

        // R9: gate on, never armed
        repeat (300) @(negedge clk);
        reg_read(2'd2, d); check("R9 no valid without arm", d[0], 0);
        reg_read(2'd1, d); check("R9 no result without arm", d, 0);
        reg_write(2'd2, 32'h0);

        // R3: several period ratios and window lengths
        measure("R3 20ns x64",    20.0, 64,   64 * 20000,   REF_PS);
        measure("R3 7ns x100",    7.0,  100,  100 * 7000,   REF_PS);
        measure("R3 33ns x37",    33.0, 37,   37 * 33000,   REF_PS);
        measure("R3 10.3ns x200", 10.3, 200,  200 * 10300,  REF_PS);
        measure("R3 13ns x1024",  13.0, 1024, 1024 * 13000, REF_PS);

        // R8: trivial windows
        measure("R8 window 0", 50.0, 0, 50000, REF_PS);
        measure("R8 window 1", 50.0, 1, 50000, REF_PS);

        // R7: 1024 x 50ns = 5120 ref cycles, beyond the 12-bit result
        measure("R7 saturation", 50.0, 1024, longint'(RES_MAX) * REF_PS, 0);

        // R6: armed but gate off
        meas_half = 10.0;
        reg_write(2'd2, 32'h0);
        reg_write(2'd0, 32'h0100_0010);
        repeat (3000) @(negedge clk);
        reg_read(2'd2, d); check("R6 no valid with gate off", d[0], 0);
        reg_read(2'd1, d); check("R6 zero result with gate off", d, 0);
        reg_write(2'd0, 32'h0);

        repeat (20) @(negedge clk);
        check("scoreboard drained", exp_q.size() + act_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule